// File: doc/BRIEF.md
# SPI Serial Clock Generator with Cascaded Dividers

This block derives the serial clock of an SPI controller from the module clock. Two dividers in series set the rate. The first is a linear stage that divides by (pre + 1). The second is a power-of-two stage that divides the result by 2^post. Both settings come from the upper byte of the controller's control word. While a burst is active the block toggles the serial clock with a 50 percent duty cycle. It also issues one-cycle launch and sample strobes that the shift logic uses to move data out and capture data in.

Outside a burst both counters are held at zero and the serial clock rests at its idle level. The idle level is the clock polarity setting. A change to that setting is applied only after one full serial clock period. This stops a polarity flip from reaching the line at the same moment as a chip-select change, where a device could read it as a clock edge. The divider and polarity settings are assumed to be held stable while a burst is running.

Top module: `spi_clkdiv_top`

## Requirements
- R1: The control input spans bits 15:8. Bits 15:12 hold the linear pre-divide value `pre`, and bits 11:8 hold the exponent `post`. The serial clock holds each level for H = (pre+1)·2^post module clock cycles, so its period is 2H.
- R2: With pre = 0 and post = 0, the serial clock changes level on every module clock edge while a burst is active, giving half the input frequency.
- R3: For every setting, the high and low phases of the serial clock are each exactly H cycles long, including the largest exponent.
- R4: The first serial clock transition of a burst happens at the H-th rising module clock edge at which `burst_active` is sampled high. Before that edge, the clock stays at its idle level.
- R5: When `burst_active` is sampled low, the serial clock returns to its idle level at that edge and both divider counters clear. A following burst therefore starts with the full R4 timing, even if the previous burst ended in the middle of a phase.
- R6: The idle level equals the applied polarity. During reset, the polarity input is loaded directly. After reset, a changed polarity input reaches `sclk` at the 2H-th clock edge after the change, and not before.
- R7: Each serial clock transition is marked by a one-cycle strobe in the cycle after it. With `cpha` = 0, a transition away from the idle level raises `launch_stb` and a transition back to idle raises `sample_stb`. With `cpha` = 1, the two strobes are swapped.
- R8: The two strobes are never high together. Neither strobe is raised outside a burst or in a cycle without a clock transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_div | input | 8 | Control bits 15:8: pre-divide in 15:12, exponent in 11:8 |
| burst_active | input | 1 | High while a transfer burst is running |
| cpol | input | 1 | Requested clock polarity (idle level) |
| cpha | input | 1 | Clock phase select; swaps launch and sample strobes |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle pulse: drive next data bit |
| sample_stb | output | 1 | One-cycle pulse: capture incoming data bit |

## Verification
The divider is exercised with several settings, and each one separates a different fault:
- pre = 0, post = 0 checks the toggle-every-cycle corner.
- Pure linear settings (post = 0) and pure exponent settings (pre = 0) show whether each stage works on its own.
- A mixed setting (pre = 2, post = 1) exposes a swapped or wrongly ordered cascade.
- The largest exponent checks the top of the post counter range.

Each burst is run with both polarities and both phase settings, so that a strobe assigned to the wrong clock direction shows up. One burst is cut off in the middle of a high phase to show the return to idle and the fresh start of the next burst. Polarity changes are timed edge by edge against the 2H rule.

// File: rtl/spi_clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions and types for the SPI clock divider.
// Assumes the divider fields sit in the upper byte of the control word.
package spi_clkdiv_pkg;
    localparam int CTRL_HI  = 15;
    localparam int CTRL_LO  = 8;
    localparam int PRE_W    = 4;
    localparam int POST_W   = 4;
    localparam int PRE_LSB  = 12;
    localparam int POST_LSB = 8;

    typedef logic [CTRL_HI:CTRL_LO] ctrl_t;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } div_sel_t;

    // Split the control byte into its two divider fields.
    function automatic div_sel_t decode_ctrl(input ctrl_t w);
        div_sel_t d;
        d.pre  = w[PRE_LSB  +: PRE_W];
        d.post = w[POST_LSB +: POST_W];
        return d;
    endfunction
endpackage

// File: rtl/clkdiv_prestage.sv
`timescale 1ns/1ps
// Linear pre-divider. Emits a one-cycle tick every (pre_sel+1) cycles
// while run is high. Holds its count at zero when run is low.
// Assumes pre_sel is stable while run is high.
module clkdiv_prestage #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_sel,
    output logic             pre_tick
);
    logic [PRE_W-1:0] cnt_q;

    assign pre_tick = run && (cnt_q == pre_sel);

    // Count module clocks and wrap when the tick fires.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    pre_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= pre_sel));

    // R5
    pre_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_poststage.sv
`timescale 1ns/1ps
// Power-of-two post-divider. Counts pre-stage ticks and emits a
// half-period tick on every 2^post_sel-th one. Cleared when run is low.
// Assumes post_sel is stable while run is high.
module clkdiv_poststage #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pre_tick,
    input  logic [POST_W-1:0] post_sel,
    output logic              half_tick
);
    localparam int CNT_W = (1 << POST_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // The wrap limit is 2^post_sel - 1, built as a mask of ones.
    assign lim       = ~({CNT_W{1'b1}} << post_sel);
    assign half_tick = pre_tick && (cnt_q == lim);

    // Count pre-stage ticks and wrap on the half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= half_tick ? '0 : cnt_q + 1'b1;
        end
    end

    // R1
    post_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim));

    // R5
    post_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_edgegen.sv
`timescale 1ns/1ps
// Edge generator. Flips the clock phase on each half-period tick and
// raises the launch or sample strobe for that transition. The phase
// rests at 0 (idle) when run is low. phase_q = 1 means away from idle.
module clkdiv_edgegen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic half_tick,
    input  logic cpha,
    output logic phase_q,
    output logic launch_q,
    output logic sample_q
);
    logic leading;

    assign leading = ~phase_q;

    // Advance the phase and tag the transition with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q  <= 1'b0;
            launch_q <= 1'b0;
            sample_q <= 1'b0;
        end else if (half_tick) begin
            phase_q  <= ~phase_q;
            launch_q <= leading ^ cpha;
            sample_q <= ~(leading ^ cpha);
        end else begin
            launch_q <= 1'b0;
            sample_q <= 1'b0;
        end
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({launch_q, sample_q}));

    // R8
    strobe_on_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_q || sample_q) |-> !$stable(phase_q));

    // R7
    launch_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_q && !$past(cpha)) |-> phase_q);

    // R5
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!phase_q && !launch_q && !sample_q));
endmodule

// File: rtl/clkdiv_polsettle.sv
`timescale 1ns/1ps
// Polarity settle unit. Applies a new requested polarity only after a
// full serial clock period (2H module cycles) has passed since the
// request changed. During reset the request is loaded directly.
module clkdiv_polsettle #(
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol_req,
    input  logic [PRE_W-1:0]  pre_sel,
    input  logic [POST_W-1:0] post_sel,
    output logic              cpol_eff_q
);
    localparam int SET_W = PRE_W + 1 + (1 << POST_W);

    logic [SET_W-1:0] cnt_q;
    logic [SET_W-1:0] period;
    logic [POST_W:0]  shamt;

    assign shamt  = {1'b0, post_sel} + (POST_W+1)'(1);
    assign period = ({{(SET_W-PRE_W){1'b0}}, pre_sel} + SET_W'(1)) << shamt;

    // Wait one full period of mismatch, then apply the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_eff_q <= cpol_req;
            cnt_q      <= '0;
        end else if (cpol_req == cpol_eff_q) begin
            cnt_q <= '0;
        end else if (cnt_q == period - SET_W'(1)) begin
            cpol_eff_q <= cpol_req;
            cnt_q      <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    pol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpol_eff_q) |-> (cpol_eff_q == $past(cpol_req)));

    // R6
    pol_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpol_eff_q) |-> ($past(cnt_q) == $past(period) - SET_W'(1)));
endmodule

// File: rtl/spi_clkdiv_top.sv
`timescale 1ns/1ps
// SPI serial clock generator. Chains the linear pre-divider, the
// power-of-two post-divider, the edge generator and the polarity settle
// unit. sclk is the phase combined with the applied polarity.
// Assumes ctrl_div, cpol and cpha are stable during a burst.
module spi_clkdiv_top
    import spi_clkdiv_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CTRL_HI:CTRL_LO] ctrl_div,
    input  logic                   burst_active,
    input  logic                   cpol,
    input  logic                   cpha,
    output logic                   sclk,
    output logic                   launch_stb,
    output logic                   sample_stb
);
    div_sel_t sel;
    logic     pre_tick;
    logic     half_tick;
    logic     phase_q;
    logic     cpol_eff;

    assign sel = decode_ctrl(ctrl_div);

    clkdiv_prestage #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (burst_active),
        .pre_sel  (sel.pre),
        .pre_tick (pre_tick)
    );

    clkdiv_poststage #(.POST_W(POST_W)) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (burst_active),
        .pre_tick  (pre_tick),
        .post_sel  (sel.post),
        .half_tick (half_tick)
    );

    clkdiv_edgegen u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (burst_active),
        .half_tick (half_tick),
        .cpha      (cpha),
        .phase_q   (phase_q),
        .launch_q  (launch_stb),
        .sample_q  (sample_stb)
    );

    clkdiv_polsettle #(.PRE_W(PRE_W), .POST_W(POST_W)) u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol_req   (cpol),
        .pre_sel    (sel.pre),
        .post_sel   (sel.post),
        .cpol_eff_q (cpol_eff)
    );

    assign sclk = phase_q ^ cpol_eff;

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> (sclk == cpol_eff));

    // R8
    no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> !(launch_stb || sample_stb));
endmodule

// File: tb/spi_clkdiv_top_test.sv
`timescale 1ns/1ps
module spi_clkdiv_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl_byte = 8'h00;
    logic       burst_active = 1'b0;
    logic       cpol = 1'b1;
    logic       cpha = 1'b0;
    logic       sclk, launch_stb, sample_stb;

    int compared = 0;
    int mismatched = 0;
    logic cur_cpol = 1'b1;

    always #5 clk = ~clk;

    spi_clkdiv_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_div     (ctrl_byte),
        .burst_active (burst_active),
        .cpol         (cpol),
        .cpha         (cpha),
        .sclk         (sclk),
        .launch_stb   (launch_stb),
        .sample_stb   (sample_stb)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
        end
    endtask

    // Reset state: idle level is the polarity held during reset (R6), no strobes (R8).
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R6", "sclk after reset", sclk, 1);
        check("R8", "launch after reset", launch_stb, 0);
        check("R8", "sample after reset", sample_stb, 0);
    endtask

    // One burst of len edges, checked edge by edge, then return to idle (R5).
    task automatic t_burst(input int pre, input int post, input logic ph,
                           input int len, input string tag);
        int h = (pre + 1) << post;
        @(negedge clk);
        ctrl_byte = {pre[3:0], post[3:0]};
        cpha = ph;
        burst_active = 1'b1;
        for (int k = 1; k <= len; k++) begin
            int  flips = k / h;
            logic phs = flips[0];
            logic edg = (k % h) == 0;
            logic exp_l = edg && (phs ^ ph);
            logic exp_s = edg && !(phs ^ ph);
            @(posedge clk); @(negedge clk);
            check((k <= h) ? "R4" : tag, "sclk", sclk, int'(phs ^ cur_cpol));
            check("R7", "launch_stb", launch_stb, exp_l);
            check("R7", "sample_stb", sample_stb, exp_s);
        end
        burst_active = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check("R5", "sclk idle", sclk, cur_cpol);
            check("R8", "idle strobes", launch_stb | sample_stb, 0);
        end
    endtask

    // Polarity change while idle: old level until the 2H-th edge (R6).
    task automatic t_pol(input logic newp, input int pre, input int post);
        int p = ((pre + 1) << post) * 2;
        @(negedge clk);
        ctrl_byte = {pre[3:0], post[3:0]};
        cpol = newp;
        for (int k = 1; k <= p + 2; k++) begin
            @(posedge clk); @(negedge clk);
            check("R6", "sclk polarity settle", sclk, (k >= p) ? newp : cur_cpol);
        end
        cur_cpol = newp;
    endtask

    initial begin
        t_reset();
        t_burst(0, 0, 1'b0, 12, "R2");
        t_pol(1'b0, 1, 1);
        t_burst(2, 1, 1'b1, 40, "R1");
        t_burst(5, 0, 1'b0, 30, "R3");
        t_burst(0, 3, 1'b0, 50, "R3");
        t_burst(1, 1, 1'b0, 6, "R5");
        t_burst(1, 1, 1'b1, 20, "R5");
        t_pol(1'b1, 0, 2);
        t_burst(0, 3, 1'b1, 50, "R3");
        t_burst(3, 2, 1'b0, 70, "R1");
        t_burst(0, 15, 1'b0, (1 << 15) + 4, "R3");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule